// File: doc/BRIEF.md
# Raw Four-Level Symbol Task Engine

This block runs the uncoded data tasks of a four-level FSK modem. In transmit mode the host loads bytes into a small data buffer and then issues a task. The engine turns each byte into four two-bit symbols and presents them as signed three-bit level codes, one per symbol period. A short task sends one byte as 4 symbols. A long task sends a whole buffer of bytes, 24 symbols at the default size. In receive mode a short task slices the next four incoming levels back into two-bit values and packs them into one byte.

The symbol period comes from a divider of the system clock, selected by a two-bit rate field. The default base ratio of 1024 turns a 4.9152 MHz clock into 4800 symbols per second. An inversion control negates the levels in both directions.

Task hand-off is double-buffered. As soon as a transmit task's bytes have been copied into an internal staging slot, the `free` flag rises, so the host can queue the next task while the current one is still being sent. A separate `empty` flag marks the end of transmission. An abort task cancels all activity at once.

Top module: `quad_sym_engine`

## Requirements
- R1: After reset the outputs read as follows: `sym_out` = 0, `tx_idle` = 1, `free` = 1, `empty` = 1, `rx_byte` = 0 and `sym_strobe` = 0.
- R2: `sym_strobe` is a one-cycle pulse. Its period in clocks depends on `rate_sel`: BASE_DIV for 00, BASE_DIV/2 for 01, BASE_DIV/4 for 10 and 2*BASE_DIV for 11.
- R3: In transmit mode, task code 1 sends buffer byte 0 as four symbols, bits [7:6] first and bits [1:0] last. The level codes are two's complement: pair 01 gives +3 (3'b011), 00 gives +1 (3'b001), 10 gives -1 (3'b111) and 11 gives -3 (3'b101). `sym_out` changes only in the cycle where `sym_strobe` is high, or after an abort.
- R4: In transmit mode, task code 2 sends buffer bytes 0 to BUF_BYTES-1 in address order, each byte most significant pair first: 4*BUF_BYTES symbols in all.
- R5: When `invert` is 1, each transmitted level is negated, and each received level is negated before it is sliced.
- R6: Accepting a data task drops `free`. In transmit mode, `free` rises again once the bytes have been copied into the staging slot, before the first symbol of the task goes out. While `free` is 0, data tasks and buffer writes are ignored.
- R7: A task queued while another is being sent follows it with no idle symbol in between. `free` stays 0 while the staging slot is still occupied.
- R8: At the first strobe with no symbol left to send and no task pending, `sym_out` becomes 0 and both `tx_idle` and `empty` become 1. Accepting a transmit data task clears `empty`.
- R9: In receive mode, task code 1 samples `sym_in` at each of the next four strobes and slices each sample: a value of 2 or more gives 01, 0 or 1 gives 00, -1 or -2 gives 10, and -3 or less gives 11. The first sample goes to bits [7:6]. `rx_byte` takes the result and `free` rises in the cycle of the fourth strobe.
- R10: Task code 7 (abort) is accepted whatever the state of `free`. In the next cycle `sym_out` = 0 and `tx_idle`, `free` and `empty` are all 1. No further symbol of a cancelled task is sent, and a cancelled receive leaves `rx_byte` unchanged.
- R11: Code 0, codes 3 to 6, and code 2 in receive mode are ignored: `free`, `empty`, `sym_out` and `rx_byte` do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_mode | input | 1 | 1 = transmit, 0 = receive |
| invert | input | 1 | Negate symbol levels |
| rate_sel | input | 2 | Symbol divider select |
| buf_we | input | 1 | Data buffer write strobe |
| buf_addr | input | ADDR_W | Data buffer byte address |
| buf_wdata | input | 8 | Data buffer write byte |
| task_we | input | 1 | Task write strobe |
| task_code | input | 3 | Task code: 0 none, 1 short, 2 long, 7 abort |
| sym_in | input | 3 | Received level, signed |
| sym_strobe | output | 1 | Symbol period pulse |
| sym_out | output | 3 | Transmitted level, signed |
| tx_idle | output | 1 | Transmit output held at idle |
| free | output | 1 | Buffer may be written and a task issued |
| empty | output | 1 | Transmission finished |
| rx_byte | output | 8 | Last received byte |

## Verification
Two events can fall on the same clock edge. One is the symbol tick that moves the staging slot into the serializer. The other is the copy of a waiting task into that same slot. The bench provokes this by queuing a third task while the second still fills the slot, and it also rewrites the buffer while that task waits. It then judges the result by three things: the recorded stream must run through all 32 expected levels with no gap, `free` must stay low until the hand-off, and the delayed task must carry its original byte.

// File: rtl/qse_pkg.sv
package qse_pkg;

   typedef enum logic [2:0] {
      TK_NONE  = 3'd0,
      TK_SHORT = 3'd1,
      TK_LONG  = 3'd2,
      TK_ABORT = 3'd7
   } task_e;

   // two-bit value to signed level code, optionally negated
   function automatic logic [2:0] pair_to_level(input logic [1:0] pr, input logic neg);
      logic [2:0] lv;
      case (pr)
         2'b01:   lv = 3'b011;
         2'b00:   lv = 3'b001;
         2'b10:   lv = 3'b111;
         default: lv = 3'b101;
      endcase
      if (neg) lv = 3'(-lv);
      return lv;
   endfunction

   // signed level code to two-bit value by threshold slicing
   function automatic logic [1:0] level_to_pair(input logic [2:0] lv, input logic neg);
      logic signed [3:0] v;
      v = signed'({lv[2], lv});
      if (neg) v = -v;
      if (v >= 4'sd2)       return 2'b01;
      else if (v >= 4'sd0)  return 2'b00;
      else if (v >= -4'sd2) return 2'b10;
      else                  return 2'b11;
   endfunction

endpackage

// File: rtl/qse_rate_gen.sv
module qse_rate_gen #(
   parameter int BASE_DIV = 1024,
   localparam int CW = $clog2(2 * BASE_DIV) + 1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] rate_sel,
   output logic       tick
);

   logic [CW-1:0] cnt_q;
   logic [CW-1:0] reload;

   always_comb begin
      case (rate_sel)
         2'b00:   reload = CW'(BASE_DIV - 1);
         2'b01:   reload = CW'(BASE_DIV / 2 - 1);
         2'b10:   reload = CW'(BASE_DIV / 4 - 1);
         default: reload = CW'(2 * BASE_DIV - 1);
      endcase
   end

   assign tick = (cnt_q == '0);

   always_ff @(posedge clk) begin
      if (!rst_n)    cnt_q <= '0;
      else if (tick) cnt_q <= reload;
      else           cnt_q <= cnt_q - 1'b1;
   end

endmodule

// File: rtl/qse_tx_path.sv
module qse_tx_path
   import qse_pkg::*;
#(
   parameter int BUF_BYTES = 6,
   localparam int HW = BUF_BYTES * 8,
   localparam int NW = $clog2(BUF_BYTES * 4 + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          tick,
   input  logic          flush,
   input  logic          invert,
   input  logic          load,
   input  logic [HW-1:0] load_data,
   input  logic [NW-1:0] load_syms,
   output logic          slot_busy,
   output logic          take,
   output logic          starve,
   output logic [2:0]    sym_out,
   output logic          idle
);

   logic [HW-1:0] slot_q;
   logic [NW-1:0] slot_n;
   logic          slot_v;
   logic [HW-1:0] ser_q;
   logic [NW-1:0] ser_n;

   assign slot_busy = slot_v;
   assign take      = tick && (ser_n == '0) && slot_v;
   assign starve    = tick && (ser_n == '0) && !slot_v;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         slot_q  <= '0;
         slot_n  <= '0;
         slot_v  <= 1'b0;
         ser_q   <= '0;
         ser_n   <= '0;
         sym_out <= 3'b000;
         idle    <= 1'b1;
      end else if (flush) begin
         slot_v  <= 1'b0;
         ser_n   <= '0;
         sym_out <= 3'b000;
         idle    <= 1'b1;
      end else begin
         if (tick) begin
            if (ser_n != '0) begin
               sym_out <= pair_to_level(ser_q[HW-1 -: 2], invert);
               ser_q   <= ser_q << 2;
               ser_n   <= ser_n - 1'b1;
               idle    <= 1'b0;
            end else if (slot_v) begin
               sym_out <= pair_to_level(slot_q[HW-1 -: 2], invert);
               ser_q   <= slot_q << 2;
               ser_n   <= slot_n - 1'b1;
               idle    <= 1'b0;
            end else begin
               sym_out <= 3'b000;
               idle    <= 1'b1;
            end
         end
         if (load) begin
            slot_q <= load_data;
            slot_n <= load_syms;
            slot_v <= 1'b1;
         end else if (take) begin
            slot_v <= 1'b0;
         end
      end
   end

endmodule

// File: rtl/qse_rx_pack.sv
module qse_rx_pack
   import qse_pkg::*;
#(
   parameter int SYMS = 4,
   localparam int BW = 2 * SYMS,
   localparam int CW = $clog2(SYMS + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          tick,
   input  logic          start,
   input  logic          flush,
   input  logic          invert,
   input  logic [2:0]    sym_in,
   output logic          done,
   output logic [BW-1:0] byte_q
);

   logic [CW-1:0] rem_q;
   logic [BW-1:0] acc_q;
   logic [1:0]    pr;
   logic [BW-1:0] nxt;

   assign pr   = level_to_pair(sym_in, invert);
   assign nxt  = {acc_q[BW-3:0], pr};
   assign done = tick && !flush && !start && (rem_q == CW'(1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rem_q  <= '0;
         acc_q  <= '0;
         byte_q <= '0;
      end else if (flush) begin
         rem_q <= '0;
      end else if (start) begin
         rem_q <= CW'(SYMS);
         acc_q <= '0;
      end else if (tick && rem_q != '0) begin
         acc_q <= nxt;
         rem_q <= rem_q - 1'b1;
         if (rem_q == CW'(1)) byte_q <= nxt;
      end
   end

endmodule

// File: rtl/quad_sym_engine.sv
module quad_sym_engine
   import qse_pkg::*;
#(
   parameter int BASE_DIV  = 1024,
   parameter int BUF_BYTES = 6,
   parameter int ADDR_W    = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tx_mode,
   input  logic              invert,
   input  logic [1:0]        rate_sel,
   input  logic              buf_we,
   input  logic [ADDR_W-1:0] buf_addr,
   input  logic [7:0]        buf_wdata,
   input  logic              task_we,
   input  logic [2:0]        task_code,
   input  logic [2:0]        sym_in,
   output logic              sym_strobe,
   output logic [2:0]        sym_out,
   output logic              tx_idle,
   output logic              free,
   output logic              empty,
   output logic [7:0]        rx_byte
);

   localparam int HW         = BUF_BYTES * 8;
   localparam int LONG_SYMS  = BUF_BYTES * 4;
   localparam int SHORT_SYMS = 4;
   localparam int NW         = $clog2(LONG_SYMS + 1);

   if (BASE_DIV < 8)
      $error("BASE_DIV must be at least 8");
   if (BASE_DIV % 4 != 0)
      $error("BASE_DIV must be a multiple of 4");
   if (BUF_BYTES < 1)
      $error("BUF_BYTES must be at least 1");
   if ((1 << ADDR_W) < BUF_BYTES)
      $error("ADDR_W too narrow for BUF_BYTES");

   logic [7:0]    buf_q [BUF_BYTES];
   logic [HW-1:0] long_data;
   logic [HW-1:0] short_data;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < BUF_BYTES; i++) buf_q[i] <= 8'h00;
      end else if (buf_we && free) begin
         for (int i = 0; i < BUF_BYTES; i++)
            if (buf_addr == ADDR_W'(i)) buf_q[i] <= buf_wdata;
      end
   end

   for (genvar g = 0; g < BUF_BYTES; g++) begin : g_cat
      assign long_data[HW-1-8*g -: 8] = buf_q[g];
   end

   if (BUF_BYTES > 1) begin : g_short_pad
      assign short_data = {buf_q[0], {(HW-8){1'b0}}};
   end else begin : g_short_full
      assign short_data = buf_q[0];
   end

   logic tick, tx_tick, rx_tick;
   logic slot_busy, take, starve, rx_done, load;
   logic pend_q, pend_long_q;
   logic is_abort, acc_tx, acc_rx;

   assign tx_tick  = tick && tx_mode;
   assign rx_tick  = tick && !tx_mode;
   assign is_abort = task_we && (task_code == TK_ABORT);
   assign acc_tx   = task_we && free && tx_mode &&
                     (task_code == TK_SHORT || task_code == TK_LONG);
   assign acc_rx   = task_we && free && !tx_mode && (task_code == TK_SHORT);
   assign load     = pend_q && !is_abort && (!slot_busy || take);

   qse_rate_gen #(.BASE_DIV(BASE_DIV)) u_rate (
      .clk      (clk),
      .rst_n    (rst_n),
      .rate_sel (rate_sel),
      .tick     (tick)
   );

   qse_tx_path #(.BUF_BYTES(BUF_BYTES)) u_tx (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick      (tx_tick),
      .flush     (is_abort),
      .invert    (invert),
      .load      (load),
      .load_data (pend_long_q ? long_data : short_data),
      .load_syms (pend_long_q ? NW'(LONG_SYMS) : NW'(SHORT_SYMS)),
      .slot_busy (slot_busy),
      .take      (take),
      .starve    (starve),
      .sym_out   (sym_out),
      .idle      (tx_idle)
   );

   qse_rx_pack #(.SYMS(4)) u_rx (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick   (rx_tick),
      .start  (acc_rx && !is_abort),
      .flush  (is_abort),
      .invert (invert),
      .sym_in (sym_in),
      .done   (rx_done),
      .byte_q (rx_byte)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sym_strobe  <= 1'b0;
         free        <= 1'b1;
         empty       <= 1'b1;
         pend_q      <= 1'b0;
         pend_long_q <= 1'b0;
      end else begin
         sym_strobe <= tick;
         if (is_abort) begin
            free   <= 1'b1;
            empty  <= 1'b1;
            pend_q <= 1'b0;
         end else begin
            if (starve && !pend_q) empty <= 1'b1;
            if (acc_tx) begin
               free        <= 1'b0;
               pend_q      <= 1'b1;
               pend_long_q <= (task_code == TK_LONG);
               empty       <= 1'b0;
            end else if (load) begin
               pend_q <= 1'b0;
               free   <= 1'b1;
            end
            if (acc_rx)  free <= 1'b0;
            if (rx_done) free <= 1'b1;
         end
      end
   end

endmodule

// File: rtl/quad_sym_engine_chk.sv
module quad_sym_engine_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       task_we,
   input logic [2:0] task_code,
   input logic       sym_strobe,
   input logic [2:0] sym_out,
   input logic       tx_idle,
   input logic       free,
   input logic       empty
);

   // R3: an active level is always one of the four odd codes
   p_odd_level_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !tx_idle |-> sym_out[0]);

   // R3: output moves only with the strobe or after an abort
   p_out_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!sym_strobe && !$past(task_we && task_code == 3'd7)) |-> $stable(sym_out));

   // R2: strobe lasts a single cycle
   p_strobe_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
      sym_strobe |=> !sym_strobe);

   // R6: an accepted short task drops free
   p_free_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (free && task_we && task_code == 3'd1) |=> !free);

   // R10: abort restores the idle flags
   p_abort_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (task_we && task_code == 3'd7) |=> (free && empty && tx_idle && sym_out == 3'd0));

   // R8: idle output is level zero
   p_idle_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
      tx_idle |-> (sym_out == 3'd0));

   // R8: empty never shows while a symbol is driven
   p_empty_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
      empty |-> tx_idle);

endmodule

bind quad_sym_engine quad_sym_engine_chk u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .task_we    (task_we),
   .task_code  (task_code),
   .sym_strobe (sym_strobe),
   .sym_out    (sym_out),
   .tx_idle    (tx_idle),
   .free       (free),
   .empty      (empty)
);

// File: tb/quad_sym_engine_tb_top.sv
module quad_sym_engine_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int BDIV       = 16;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tx_mode = 1'b1;
   logic       invert = 1'b0;
   logic [1:0] rate_sel = 2'b00;
   logic       buf_we = 1'b0;
   logic [2:0] buf_addr = 3'd0;
   logic [7:0] buf_wdata = 8'h00;
   logic       task_we = 1'b0;
   logic [2:0] task_code = 3'd0;
   logic [2:0] sym_in = 3'd0;
   logic       sym_strobe, tx_idle, free, empty;
   logic [2:0] sym_out;
   logic [7:0] rx_byte;

   int checks = 0;
   int fails  = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   quad_sym_engine #(.BASE_DIV(BDIV), .BUF_BYTES(6), .ADDR_W(3)) dut_i (
      .clk(clk), .rst_n(rst_n), .tx_mode(tx_mode), .invert(invert),
      .rate_sel(rate_sel), .buf_we(buf_we), .buf_addr(buf_addr),
      .buf_wdata(buf_wdata), .task_we(task_we), .task_code(task_code),
      .sym_in(sym_in), .sym_strobe(sym_strobe), .sym_out(sym_out),
      .tx_idle(tx_idle), .free(free), .empty(empty), .rx_byte(rx_byte)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic logic [2:0] lvl(input logic [1:0] pr, input logic neg);
      logic [2:0] v;
      case (pr)
         2'b01: v = 3'd3;
         2'b00: v = 3'd1;
         2'b10: v = 3'b111;
         default: v = 3'b101;
      endcase
      return neg ? 3'(-v) : v;
   endfunction

   task automatic wait_strobe();
      do @(negedge clk); while (!sym_strobe);
   endtask

   task automatic issue(input logic [2:0] code);
      task_we = 1'b1; task_code = code;
      @(negedge clk);
      task_we = 1'b0; task_code = 3'd0;
   endtask

   task automatic wr(input int a, input logic [7:0] d);
      buf_we = 1'b1; buf_addr = 3'(a); buf_wdata = d;
      @(negedge clk);
      buf_we = 1'b0;
   endtask

   task automatic t_reset();
      chk(sym_out == 3'd0, "R1 sym_out", int'(sym_out), 0);
      chk(tx_idle, "R1 tx_idle", int'(tx_idle), 1);
      chk(free, "R1 free", int'(free), 1);
      chk(empty, "R1 empty", int'(empty), 1);
      chk(rx_byte == 8'h00, "R1 rx_byte", int'(rx_byte), 0);
   endtask

   task automatic t_rate();
      int exp_div [4] = '{BDIV, BDIV/2, BDIV/4, 2*BDIV};
      for (int s = 0; s < 4; s++) begin
         int n;
         rate_sel = 2'(s);
         wait_strobe(); wait_strobe();
         n = 0;
         do begin @(negedge clk); n++; end while (!sym_strobe);
         chk(n == exp_div[s], "R2 strobe period", n, exp_div[s]);
      end
      rate_sel = 2'b01;
      wait_strobe(); wait_strobe();
   endtask

   task automatic t_tx_short(input logic [7:0] b, input logic neg);
      invert = neg;
      wr(0, b);
      wait_strobe();
      issue(3'd1);
      chk(!empty, "R8 empty cleared", int'(empty), 0);
      @(negedge clk);
      chk(free, "R6 free after copy", int'(free), 1);
      chk(tx_idle, "R6 not yet sending", int'(tx_idle), 1);
      for (int i = 0; i < 4; i++) begin
         logic [2:0] e;
         wait_strobe();
         e = lvl(b[7-2*i -: 2], neg);
         chk(sym_out == e, neg ? "R5 inverted tx level" : "R3 tx level", int'(sym_out), int'(e));
      end
      wait_strobe();
      chk(sym_out == 3'd0 && tx_idle, "R8 idle after task", int'(sym_out), 0);
      chk(empty, "R8 empty", int'(empty), 1);
      invert = 1'b0;
   endtask

   task automatic t_tx_long();
      logic [7:0] d [6] = '{8'h1B, 8'hE4, 8'h5A, 8'hC3, 8'h00, 8'hFF};
      int bad = 0;
      for (int i = 0; i < 6; i++) wr(i, d[i]);
      wait_strobe();
      issue(3'd2);
      for (int i = 0; i < 24; i++) begin
         logic [2:0] e;
         wait_strobe();
         e = lvl(d[i/4][7-2*(i%4) -: 2], 1'b0);
         if (sym_out != e) bad++;
      end
      chk(bad == 0, "R4 long task symbol stream", bad, 0);
      wait_strobe();
      chk(empty && tx_idle, "R4 end after 24 symbols", int'(empty), 1);
   endtask

   task automatic t_queue();
      logic [7:0] a = 8'h6C;
      logic [7:0] c = 8'h93;
      logic [7:0] bb [6] = '{8'h12, 8'h34, 8'h56, 8'h78, 8'h9A, 8'hBC};
      logic [2:0] got [33];
      int bad = 0;
      wr(0, a);
      wait_strobe();
      fork
         begin
            for (int i = 0; i < 33; i++) begin
               wait_strobe();
               got[i] = sym_out;
            end
         end
         begin
            issue(3'd1);
            while (!free) @(negedge clk);
            for (int i = 0; i < 6; i++) wr(i, bb[i]);
            issue(3'd2);
            while (!free) @(negedge clk);
            wr(0, c);
            issue(3'd1);
            chk(!free, "R7 free held while slot full", int'(free), 0);
            wr(0, 8'hFF);
            while (!free) @(negedge clk);
         end
      join
      for (int i = 0; i < 32; i++) begin
         logic [7:0] src;
         logic [2:0] e;
         if (i < 4)       src = a;
         else if (i < 28) src = bb[(i-4)/4];
         else             src = c;
         e = lvl(src[7-2*(i%4) -: 2], 1'b0);
         if (got[i] != e) bad++;
      end
      chk(bad == 0, "R7 back-to-back stream, R6 write ignored", bad, 0);
      chk(got[32] == 3'd0, "R8 idle after queue", int'(got[32]), 0);
      chk(empty, "R8 empty after queue", int'(empty), 1);
   endtask

   task automatic rx_run(input logic [2:0] s [4], input logic neg,
                         input logic [7:0] exp, input string req);
      tx_mode = 1'b0; invert = neg;
      sym_in = s[0];
      wait_strobe();
      issue(3'd1);
      chk(!free, "R9 free low while receiving", int'(free), 0);
      for (int i = 0; i < 4; i++) begin
         wait_strobe();
         if (i < 3) sym_in = s[i+1];
         if (i == 1) issue(3'd1);
      end
      chk(rx_byte == exp, req, int'(rx_byte), int'(exp));
      chk(free, "R9 free after fourth symbol, R6 extra task ignored", int'(free), 1);
      invert = 1'b0;
   endtask

   task automatic t_rx();
      logic [2:0] s [4];
      for (int i = 0; i < 4; i++) s[i] = lvl(2'(8'hC6 >> (6-2*i)), 1'b0);
      rx_run(s, 1'b0, 8'hC6, "R9 rx byte");
      for (int i = 0; i < 4; i++) s[i] = lvl(2'(8'h2D >> (6-2*i)), 1'b1);
      rx_run(s, 1'b1, 8'h2D, "R5 inverted rx byte");
      s = '{3'b010, 3'b000, 3'b110, 3'b100};
      rx_run(s, 1'b0, 8'h4B, "R9 slicer thresholds");
      rx_run(s, 1'b1, 8'h85, "R5 slicer with inversion");
   endtask

   task automatic t_ignore();
      logic [7:0] prev = rx_byte;
      tx_mode = 1'b0;
      wait_strobe();
      issue(3'd2);
      chk(free, "R11 long ignored in rx", int'(free), 1);
      issue(3'd0);
      issue(3'd4);
      chk(free, "R11 null ignored", int'(free), 1);
      for (int i = 0; i < 5; i++) wait_strobe();
      chk(rx_byte == prev, "R11 rx_byte unchanged", int'(rx_byte), int'(prev));
      tx_mode = 1'b1;
      issue(3'd3);
      for (int i = 0; i < 2; i++) wait_strobe();
      chk(empty && tx_idle && sym_out == 3'd0, "R11 code 3 ignored in tx", int'(empty), 1);
   endtask

   task automatic t_abort();
      logic [7:0] prev;
      int bad = 0;
      tx_mode = 1'b1;
      for (int i = 0; i < 6; i++) wr(i, 8'h11);
      wait_strobe();
      issue(3'd2);
      for (int i = 0; i < 3; i++) wait_strobe();
      issue(3'd7);
      chk(sym_out == 3'd0 && tx_idle, "R10 output idle after abort", int'(sym_out), 0);
      chk(free && empty, "R10 flags after abort", int'({free, empty}), 3);
      for (int i = 0; i < 4; i++) begin
         wait_strobe();
         if (sym_out != 3'd0) bad++;
      end
      chk(bad == 0, "R10 no symbols after abort", bad, 0);
      tx_mode = 1'b0;
      prev = rx_byte;
      sym_in = 3'd3;
      wait_strobe();
      issue(3'd1);
      wait_strobe(); wait_strobe();
      issue(3'd7);
      chk(free, "R10 rx abort frees", int'(free), 1);
      for (int i = 0; i < 4; i++) wait_strobe();
      chk(rx_byte == prev, "R10 rx byte kept", int'(rx_byte), int'(prev));
      tx_mode = 1'b1;
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_rate();
      t_tx_short(8'h1B, 1'b0);
      t_tx_short(8'hE4, 1'b1);
      t_tx_long();
      t_queue();
      t_rx();
      t_ignore();
      t_abort();
      summary();
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
      summary();
      $finish;
   end

endmodule